// File: doc/BRIEF.md
# Receive Frame Status Trailer Appender

This block sits at the tail of an Ethernet receive path, just in front of the DMA write engine. Received frame bytes flow through it unchanged. Meanwhile it counts them, including the four FCS bytes, and records any error strobes raised by the receiver during the frame: overflow, collision, framing and FCS. After the last frame byte has been accepted downstream, it places a four-byte status trailer into the same stream. The DMA engine therefore stores the trailer directly after the frame in memory, and software finds it at offset `length` from the frame start.

The trailer gives the frame length as a 12-bit count split across two bytes, the four status flags, and two running 8-bit statistics: the number of runt frames and the number of collision strobes. Software subtracts four from the reported count to get the payload length without FCS. The statistics wrap silently, and each wrap is signalled by a one-cycle pulse on a dedicated output.

The output side uses valid/ready flow control. While a trailer is pending, the input is stalled, and each trailer byte stays on the output until it is accepted.

Top module: `rxtrl_append`

## Requirements
- R1: Outside a trailer, `out_valid` equals `in_valid`, `out_data` equals `in_data`, `in_ready` equals `out_ready`, and `out_last` is 0. A byte is taken when `in_valid` and `in_ready` are both high.
- R2: The frame count is the number of bytes taken from the byte flagged `in_sof` through the byte flagged `in_eof`, both included, so it includes the FCS. Trailer byte 0 holds count bits 7..0.
- R3: Trailer byte 1 holds, from bit 7 down to bit 4: overflow, collision, framing error, FCS error. Its bits 3..0 hold count bits 11..8.
- R4: Trailer byte 2 is the runt counter and byte 3 is the collision counter. Both show their values after the updates caused by the frame just ended.
- R5: The four trailer bytes follow the taken `in_eof` byte with no frame byte in between. `out_last` is high only on trailer byte 3. `in_ready` is 0 from the cycle after the `in_eof` byte is taken until trailer byte 3 has been accepted.
- R6: The count saturates at 4095. A frame of 4096 or more bytes reports 4095 and has its overflow flag set. A frame of exactly 4095 bytes does not set the flag.
- R7: While `out_ready` is low, a trailer byte stays on the output unchanged, with `out_valid` high.
- R8: The runt counter increments when a frame ends with a count below `RUNT_MIN` (64). The collision counter increments in every cycle outside a trailer in which `err_col` is high; strobes during a trailer are ignored. Both counters wrap from 255 to 0, and each wrap raises that counter's wrap output for exactly the next cycle.
- R9: A strobe seen in any cycle outside a trailer sets its flag, and the flag stays set until the next `in_sof` byte is taken. In that cycle the flags are cleared and then take the strobes present in the same cycle.
- R10: After reset, the count, flags and both counters are 0, no trailer is pending, and both wrap outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Block accepts an input byte |
| err_ovf | input | 1 | Receiver overflow strobe |
| err_col | input | 1 | Collision strobe |
| err_fram | input | 1 | Framing error strobe |
| err_fcs | input | 1 | FCS error strobe |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Frame or trailer byte |
| out_last | output | 1 | Last byte of frame plus trailer |
| out_ready | input | 1 | Downstream accepts a byte |
| runt_wrap | output | 1 | One-cycle pulse when the runt counter wraps |
| coll_wrap | output | 1 | One-cycle pulse when the collision counter wraps |

## Verification
A wrong count or a wrong flag stays hidden until the frame ends. It then appears in trailer bytes 0 and 1 one cycle after the `in_eof` byte is taken. A counter that is off by one, or that counts strobes during a trailer, shows in bytes 2 and 3 of every later trailer, and shows as a wrap pulse in the wrong cycle. For that reason, runs of short frames with dense collision strobes drive both counters through several wraps. A fault in trailer sequencing shows at once as a missing or early `out_last`, as data that changes under backpressure, or as `in_ready` going high while a trailer is still pending.

// File: rtl/rxtrl_pkg.sv
// Shared types and constants for the receive status trailer appender.
// Assumes 8-bit stream bytes and a fixed 4-byte trailer layout.
package rxtrl_pkg;
    localparam int BYTE_W  = 8;
    localparam int LEN_W   = 12;
    localparam int TRL_N   = 4;
    localparam int IDX_W   = $clog2(TRL_N);

    typedef enum logic {ST_PASS, ST_TRAIL} st_t;

    typedef struct packed {
        logic ovf;
        logic col;
        logic fram;
        logic fcs;
    } flags_t;
endpackage

// File: rtl/rxtrl_len_track.sv
// Frame byte counter with saturation.
// Counts every byte taken from the first-byte marker onward. The count
// stops at its maximum, and a saturation flag records that bytes were lost.
// Assumes take is already qualified by the handshake.
module rxtrl_len_track #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             first,
    output logic [LEN_W-1:0] len_q,
    output logic [LEN_W-1:0] len_next,
    output logic             sat_q
);
    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

    logic [LEN_W-1:0] base;
    logic             at_max;
    logic             sat_next;

    // Next count and saturation state if the current byte is taken.
    always_comb begin
        base     = first ? '0 : len_q;
        at_max   = (base == LEN_MAX);
        len_next = at_max ? base : base + 1'b1;
        sat_next = (first ? 1'b0 : sat_q) | at_max;
    end

    // Register the count and the saturation flag on each taken byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            sat_q <= 1'b0;
        end else if (take) begin
            len_q <= len_next;
            sat_q <= sat_next;
        end
    end

    assert_len_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !first && len_q == LEN_MAX) |=> (sat_q && len_q == LEN_MAX));

    assert_len_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && first) |=> (len_q == 1 && !sat_q));
endmodule

// File: rtl/rxtrl_flag_hold.sv
// Sticky error flags for one frame.
// While active, each strobe sets its flag. On clear, the flags restart
// from the strobes of the current cycle.
module rxtrl_flag_hold
    import rxtrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   active,
    input  logic   clear,
    input  flags_t strb,
    output flags_t flags_q
);
    // Accumulate strobes while active and restart at a frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (active)
            flags_q <= clear ? strb : (flags_q | strb);
    end

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && clear && strb == '0) |=> (flags_q == '0));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && flags_q.col) |=> flags_q.col);
endmodule

// File: rtl/rxtrl_stat_cnt.sv
// Wrapping statistic counter.
// Pulses wrap for one cycle after it rolls from all-ones to zero.
module rxtrl_stat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt_q,
    output logic         wrap_q
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    // Count events and flag the rollover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= inc && (cnt_q == CNT_MAX);
            if (inc)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |-> (cnt_q == '0));

    assert_cnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1 && !wrap_q));

    assert_cnt_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> ($stable(cnt_q) && !wrap_q));
endmodule

// File: rtl/rxtrl_append.sv
// Receive frame status trailer appender (top).
// Passes frame bytes through and then places a 4-byte trailer in the
// stream: count low byte; flags with count high nibble; runt count;
// collision count. Assumes in_sof marks the first byte of each frame
// and in_eof its last byte.
module rxtrl_append
    import rxtrl_pkg::*;
#(
    parameter int RUNT_MIN = 64,
    parameter int STAT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              in_ready,
    input  logic              err_ovf,
    input  logic              err_col,
    input  logic              err_fram,
    input  logic              err_fcs,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    input  logic              out_ready,
    output logic              runt_wrap,
    output logic              coll_wrap
);
    localparam int NSTAT = 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TRL_N - 1);

    st_t              st_q;
    logic [IDX_W-1:0] idx_q;
    logic             pass;
    logic             take;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_next;
    logic             sat_q;
    flags_t           strb;
    flags_t           flags_q;
    logic [NSTAT-1:0]             stat_inc;
    logic [NSTAT-1:0][STAT_W-1:0] stat_cnt;
    logic [NSTAT-1:0]             stat_wrap;

    // Handshake qualification and strobe bundling.
    always_comb begin
        pass = (st_q == ST_PASS);
        take = pass && in_valid && out_ready;
        strb = '{ovf: err_ovf, col: err_col, fram: err_fram, fcs: err_fcs};
        stat_inc[0] = take && in_eof && (len_next < LEN_W'(RUNT_MIN));
        stat_inc[1] = pass && err_col;
    end

    rxtrl_len_track #(.LEN_W(LEN_W)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .first    (in_sof),
        .len_q    (len_q),
        .len_next (len_next),
        .sat_q    (sat_q)
    );

    rxtrl_flag_hold u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (pass),
        .clear   (take && in_sof),
        .strb    (strb),
        .flags_q (flags_q)
    );

    for (genvar g = 0; g < NSTAT; g++) begin : g_stat
        rxtrl_stat_cnt #(.W(STAT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (stat_inc[g]),
            .cnt_q  (stat_cnt[g]),
            .wrap_q (stat_wrap[g])
        );
    end

    assign runt_wrap = stat_wrap[0];
    assign coll_wrap = stat_wrap[1];

    // Sequence frame pass-through and the trailer bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_PASS;
            idx_q <= '0;
        end else if (pass) begin
            if (take && in_eof) begin
                st_q  <= ST_TRAIL;
                idx_q <= '0;
            end
        end else if (out_ready) begin
            if (idx_q == LAST_IDX)
                st_q <= ST_PASS;
            idx_q <= idx_q + 1'b1;
        end
    end

    // Output mux: frame byte or trailer byte selected by index.
    always_comb begin
        in_ready  = pass && out_ready;
        out_valid = pass ? in_valid : 1'b1;
        out_last  = !pass && (idx_q == LAST_IDX);
        out_data  = in_data;
        if (!pass) begin
            case (idx_q)
                2'd0:    out_data = len_q[BYTE_W-1:0];
                2'd1:    out_data = {flags_q.ovf | sat_q, flags_q.col,
                                     flags_q.fram, flags_q.fcs,
                                     len_q[LEN_W-1:BYTE_W]};
                2'd2:    out_data = stat_cnt[0];
                default: out_data = stat_cnt[1];
            endcase
        end
    end

    assert_trail_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_trail_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last && out_ready) |=> !out_last);

    assert_trail_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_eof) |=> (out_valid && !in_ready));
endmodule

// File: tb/test_rxtrl_append.sv
// Bench for the trailer appender: directed length corners plus seeded
// random frames, strobes and backpressure, checked against a bench model.
module test_rxtrl_append;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_sof, in_eof, in_ready;
    logic [7:0] in_data;
    logic       err_ovf, err_col, err_fram, err_fcs;
    logic       out_valid, out_last, out_ready;
    logic [7:0] out_data;
    logic       runt_wrap, coll_wrap;

    always #10 clk = ~clk;

    rxtrl_append i_rxtrl_append (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
        .in_eof(in_eof), .in_ready(in_ready),
        .err_ovf(err_ovf), .err_col(err_col), .err_fram(err_fram),
        .err_fcs(err_fcs),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .runt_wrap(runt_wrap), .coll_wrap(coll_wrap)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // Bench model state
    int       mlen = 0;
    bit       movf = 0;
    bit [3:0] mflags = 0;   // {ovf, col, fram, fcs}
    int       mrunt = 0;
    int       mcol = 0;
    bit       exp_rw = 0;
    bit       exp_cw = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit [7:0] trl_byte(input int i);
        case (i)
            0: return 8'(mlen);
            1: return {movf | mflags[3], mflags[2], mflags[1], mflags[0], 4'(mlen >> 8)};
            2: return 8'(mrunt);
            default: return 8'(mcol);
        endcase
    endfunction

    function automatic bit pct(input int p);
        return ($urandom % 100) < p;
    endfunction

    // One pass-through cycle; returns whether the byte was taken.
    task automatic pcycle(input bit v, input bit [7:0] d, input bit s, input bit e,
                          input bit [3:0] st, input bit rdy, output bit acc);
        int base;
        @(negedge clk);
        in_valid = v; in_data = d; in_sof = s; in_eof = e;
        {err_ovf, err_col, err_fram, err_fcs} = st;
        out_ready = rdy;
        #2;
        chk(runt_wrap == exp_rw, "R8 runt_wrap", runt_wrap, exp_rw);
        chk(coll_wrap == exp_cw, "R8 coll_wrap", coll_wrap, exp_cw);
        chk(out_valid == v && in_ready == rdy && out_last == 0 && (!v || out_data == d),
            "R1 pass-through", {out_valid, in_ready, out_last, out_data},
            {v, rdy, 1'b0, d});
        acc = v && rdy;
        exp_cw = st[2] && (mcol == 255);
        if (st[2]) mcol = (mcol + 1) % 256;
        if (acc && s) mflags = st; else mflags |= st;
        exp_rw = 0;
        if (acc) begin
            base = s ? 0 : mlen;
            if (s) movf = 0;
            if (base == 4095) movf = 1;
            mlen = (base == 4095) ? 4095 : base + 1;
            if (e && mlen < 64) begin
                exp_rw = (mrunt == 255);
                mrunt = (mrunt + 1) % 256;
            end
        end
    endtask

    // Emit the trailer under random backpressure and check each byte.
    task automatic run_trailer(input int rdy_pct, input string what);
        int i = 0;
        bit rdy;
        while (i < 4) begin
            @(negedge clk);
            rdy = pct(rdy_pct);
            in_valid = pct(50); in_data = 8'($urandom); in_sof = pct(50); in_eof = pct(50);
            {err_ovf, err_col, err_fram, err_fcs} = 4'($urandom);
            out_ready = rdy;
            #2;
            chk(runt_wrap == exp_rw, "R8 runt_wrap", runt_wrap, exp_rw);
            chk(coll_wrap == exp_cw, "R8 coll_wrap", coll_wrap, exp_cw);
            exp_rw = 0; exp_cw = 0;
            chk(in_ready == 0, "R5 in_ready low in trailer", in_ready, 0);
            chk(out_valid == 1 && out_last == (i == 3), "R5/R7 trailer valid/last",
                {out_valid, out_last}, {1'b1, i == 3});
            case (i)
                0: chk(out_data == trl_byte(0), {"R2 count low ", what}, out_data, trl_byte(0));
                1: chk(out_data == trl_byte(1), {"R3 flags/count high ", what}, out_data, trl_byte(1));
                default: chk(out_data == trl_byte(i), {"R4 statistic ", what}, out_data, trl_byte(i));
            endcase
            if (rdy) i++;
        end
    endtask

    task automatic send_frame(input int n, input int v_pct, input int rdy_pct,
                              input int strb_pct, input string what);
        bit acc;
        bit [3:0] st;
        for (int k = 0; k < n; k++) begin
            acc = 0;
            while (!acc) begin
                st = {pct(strb_pct), pct(strb_pct), pct(strb_pct), pct(strb_pct)};
                pcycle(pct(v_pct), 8'($urandom), k == 0, k == n - 1, st, pct(rdy_pct), acc);
            end
        end
        run_trailer(rdy_pct, what);
    endtask

    task automatic idle(input int n);
        bit acc;
        for (int k = 0; k < n; k++) pcycle(0, 8'h00, 0, 0, 4'h0, pct(50), acc);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; in_valid = 0; in_data = 0; in_sof = 0; in_eof = 0;
        err_ovf = 0; err_col = 0; err_fram = 0; err_fcs = 0; out_ready = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1; #2;
        // R10 reset state
        chk(out_valid == 0 && in_ready == 1 && out_last == 0, "R10 reset outputs",
            {out_valid, in_ready, out_last}, 3'b010);
        chk(runt_wrap == 0 && coll_wrap == 0, "R10 reset wrap", {runt_wrap, coll_wrap}, 0);
        idle(2);
        // Directed corners
        send_frame(1, 100, 100, 0, "1-byte frame");       // R2 R8 runt
        send_frame(63, 100, 100, 0, "63-byte runt");
        send_frame(64, 100, 100, 0, "64-byte non-runt");
        send_frame(70, 70, 60, 0, "backpressure");        // R7
        begin : ovf_strobe
            bit acc;
            pcycle(1, 8'h11, 1, 0, 4'b1000, 1, acc);      // R9 strobe on sof cycle kept
            pcycle(1, 8'h22, 0, 0, 4'b0001, 1, acc);
            pcycle(1, 8'h33, 0, 1, 4'b0000, 1, acc);
            run_trailer(100, "R9 sticky flags");
        end
        send_frame(80, 100, 100, 0, "R9 flags cleared at sof");
        send_frame(4095, 100, 100, 0, "R6 4095 no overflow");
        send_frame(4096, 100, 100, 0, "R6 4096 saturates");
        send_frame(20, 100, 100, 0, "R6 flag cleared next frame");
        // Random short frames to wrap both counters (R8)
        for (int f = 0; f < 320; f++) begin
            send_frame(1 + ($urandom % 90), 85, 75, 25, "random");
            if (pct(30)) idle(1 + ($urandom % 3));
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule